// File: doc/BRIEF.md
# D-PHY Lane Timing Programming Sequencer

This block writes a full set of lane timing values into a MIPI D-PHY through the PHY's indirect test port, so that firmware no longer has to step through dozens of register accesses. The indirect port has two registers. One is a control word whose value 0x02 acts as a strobe. The other is a wide bus that carries either a register address or a data value. Every indirect write uses two strobe phases: the first latches the address and the second latches the data.

One cycle of `start_i` captures the lane count and the twelve timing values. The clock-lane timing values and the data-lane timing values are each supplied as their own set. The block then does the following in order:
- It emits the PHY interface configuration word.
- It holds the PHY reset-n low.
- It clears the test interface.
- It writes the five clock-lane timing registers.
- It writes seven registers for each enabled data lane, in ascending lane order.

A log port reports every completed indirect write. A one-cycle `done_o` marks the end of the run.

Top module: `dphy_tseq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `log_valid_o`, `if_cfg_we_o` and `tst_ctrl0_o` are 0 and `phy_rstz_o` is 1.
- R2: An accepted start produces a one-cycle `if_cfg_we_o` pulse. `if_cfg_o` then holds the lane count minus 1 in bits [7:0] and the STOP_WAIT constant in bits [15:8].
- R3: `phy_rstz_o` is 0 for the whole time `busy_o` is 1 and stays 0 after the run.
- R4: Before the first address is strobed, the control word goes 0x00, then 0x01 for STROBE_CYC cycles, then 0x00. This happens exactly once per run.
- R5: Each indirect write puts the address on `tst_ctrl1_o`, raises the control word from 0x00 to 0x02, and returns it to 0x00. It then puts the data on `tst_ctrl1_o` and repeats the 0x00→0x02→0x00 sequence. Each strobe lasts STROBE_CYC cycles, and `tst_ctrl1_o` does not change while the strobe is 0x02.
- R6: The clock-lane writes go first, to CLK_BASE+0 through CLK_BASE+4 (0x10010..0x10014). They carry LPX, HS-prepare, HS-zero, HS-trail and wakeup, in that order.
- R7: Data lane i is written at DATA_BASE + (i<<4) + 0..6 (0x10020 + 16·i ...). The fields are LPX, HS-prepare, HS-zero, HS-trail, TA-go, TA-get and wakeup, in that order. Lanes run from 0 to lane count − 1, so a run has 5 + 7·lanes writes.
- R8: A wakeup value of 0x100 or more is written as 0xFF. A smaller value is written unchanged.
- R9: Each completed indirect write gives one single-cycle `log_valid_o` with its address and data. The log entries appear in bus order.
- R10: `done_o` pulses for exactly one cycle, one cycle after the log entry of the last data-lane wakeup write. `busy_o` falls at the same time.
- R11: A start pulse while `busy_o` is 1 is ignored. The write count and the lane count of the running sequence do not change, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, one cycle |
| lanes_i | input | 3 | Data lane count, 1 to 4 |
| clk_lpx_i | input | 8 | Clock-lane LPX |
| clk_prep_i | input | 8 | Clock-lane HS-prepare |
| clk_zero_i | input | 8 | Clock-lane HS-zero |
| clk_trail_i | input | 8 | Clock-lane HS-trail |
| clk_wake_i | input | 16 | Clock-lane wakeup (saturated) |
| dat_lpx_i | input | 8 | Data-lane LPX |
| dat_prep_i | input | 8 | Data-lane HS-prepare |
| dat_zero_i | input | 8 | Data-lane HS-zero |
| dat_trail_i | input | 8 | Data-lane HS-trail |
| dat_tago_i | input | 8 | Data-lane TA-go |
| dat_taget_i | input | 8 | Data-lane TA-get |
| dat_wake_i | input | 16 | Data-lane wakeup (saturated) |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |
| if_cfg_o | output | 16 | PHY interface configuration word |
| if_cfg_we_o | output | 1 | Configuration word write pulse |
| phy_rstz_o | output | 1 | PHY reset-n |
| tst_ctrl0_o | output | 8 | Test-port control word |
| tst_ctrl1_o | output | 32 | Test-port address/data bus |
| log_valid_o | output | 1 | Indirect write completed |
| log_addr_o | output | 32 | Address of the completed write |
| log_data_o | output | 32 | Data of the completed write |

## Verification
The assertions assume the following about the inputs:
- `lanes_i` lies between 1 and 4 whenever `start_i` is high.
- Reset is synchronous.

Given these, the strobe-width, bus-stability and single-pulse properties depend only on the block's own sequencing. The stimulus draws lane counts from a fixed vector table that covers every value 1 to 4 and nothing else. It drives `start_i` as a one-cycle pulse between clock edges. A second start that arrives during a run uses a different valid lane count, so that any wrongful acceptance shows up in the write count.

// File: rtl/dphy_tseq_pkg.sv
package dphy_tseq_pkg;

  localparam logic [7:0] CTL_IDLE   = 8'h00;
  localparam logic [7:0] CTL_CLEAR  = 8'h01;
  localparam logic [7:0] CTL_STROBE = 8'h02;

  localparam int CLK_FIELDS = 5;
  localparam int DAT_FIELDS = 7;

  typedef enum logic [3:0] {
    X_IDLE, X_CLR_LO, X_CLR_HI, X_CLR_END,
    X_A_SET, X_A_STB, X_A_REL, X_D_SET, X_D_STB, X_D_REL
  } xfer_st_e;

  typedef enum logic [2:0] {
    T_IDLE, T_CLR_GO, T_CLR_WAIT, T_WR_GO, T_WR_WAIT
  } top_st_e;

endpackage

// File: rtl/dphy_tseq_xfer.sv
module dphy_tseq_xfer
  import dphy_tseq_pkg::*;
#(
  parameter int BUS_W      = 32,
  parameter int STROBE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_clr,
  input  logic             go_wr,
  input  logic [BUS_W-1:0] addr_i,
  input  logic [BUS_W-1:0] data_i,
  output logic             ack_o,
  output logic [7:0]       ctrl0_o,
  output logic [BUS_W-1:0] ctrl1_o,
  output logic             log_valid_o,
  output logic [BUS_W-1:0] log_addr_o,
  output logic [BUS_W-1:0] log_data_o
);

  localparam int CW = $clog2(STROBE_CYC + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(STROBE_CYC - 1);

  xfer_st_e         st_q;
  logic [CW-1:0]    cnt_q;
  logic [BUS_W-1:0] addr_q;
  logic [BUS_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= X_IDLE;
      cnt_q       <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      ack_o       <= 1'b0;
      ctrl0_o     <= CTL_IDLE;
      ctrl1_o     <= '0;
      log_valid_o <= 1'b0;
      log_addr_o  <= '0;
      log_data_o  <= '0;
    end else begin
      ack_o       <= 1'b0;
      log_valid_o <= 1'b0;
      case (st_q)
        X_IDLE: begin
          if (go_clr) begin
            ctrl0_o <= CTL_IDLE;
            st_q    <= X_CLR_LO;
          end else if (go_wr) begin
            addr_q  <= addr_i;
            data_q  <= data_i;
            ctrl1_o <= addr_i;
            ctrl0_o <= CTL_IDLE;
            st_q    <= X_A_SET;
          end
        end
        X_CLR_LO: begin
          ctrl0_o <= CTL_CLEAR;
          cnt_q   <= CNT_INIT;
          st_q    <= X_CLR_HI;
        end
        X_CLR_HI: begin
          if (cnt_q == '0) begin
            ctrl0_o <= CTL_IDLE;
            st_q    <= X_CLR_END;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        X_CLR_END: begin
          ack_o <= 1'b1;
          st_q  <= X_IDLE;
        end
        X_A_SET: begin
          ctrl0_o <= CTL_STROBE;
          cnt_q   <= CNT_INIT;
          st_q    <= X_A_STB;
        end
        X_A_STB: begin
          if (cnt_q == '0) begin
            ctrl0_o <= CTL_IDLE;
            st_q    <= X_A_REL;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        X_A_REL: begin
          ctrl1_o <= data_q;
          st_q    <= X_D_SET;
        end
        X_D_SET: begin
          ctrl0_o <= CTL_STROBE;
          cnt_q   <= CNT_INIT;
          st_q    <= X_D_STB;
        end
        X_D_STB: begin
          if (cnt_q == '0) begin
            ctrl0_o <= CTL_IDLE;
            st_q    <= X_D_REL;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        X_D_REL: begin
          log_valid_o <= 1'b1;
          log_addr_o  <= addr_q;
          log_data_o  <= data_q;
          ack_o       <= 1'b1;
          st_q        <= X_IDLE;
        end
        default: st_q <= X_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dphy_tseq_walk.sv
module dphy_tseq_walk
  import dphy_tseq_pkg::*;
#(
  parameter int LANE_W    = 3,
  parameter int TW        = 8,
  parameter int WW        = 16,
  parameter int BUS_W     = 32,
  parameter int CLK_BASE  = 32'h10010,
  parameter int DATA_BASE = 32'h10020,
  parameter int STRIDE_SH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              step,
  input  logic [LANE_W-1:0] lanes,
  input  logic [TW-1:0]     c_lpx,
  input  logic [TW-1:0]     c_prep,
  input  logic [TW-1:0]     c_zero,
  input  logic [TW-1:0]     c_trail,
  input  logic [WW-1:0]     c_wake,
  input  logic [TW-1:0]     d_lpx,
  input  logic [TW-1:0]     d_prep,
  input  logic [TW-1:0]     d_zero,
  input  logic [TW-1:0]     d_trail,
  input  logic [TW-1:0]     d_tago,
  input  logic [TW-1:0]     d_taget,
  input  logic [WW-1:0]     d_wake,
  output logic [BUS_W-1:0]  addr_o,
  output logic [BUS_W-1:0]  data_o,
  output logic              last_o
);

  localparam logic [2:0] CLK_LAST = 3'(CLK_FIELDS - 1);
  localparam logic [2:0] DAT_LAST = 3'(DAT_FIELDS - 1);

  logic              in_dat_q;
  logic [LANE_W-1:0] lane_q;
  logic [2:0]        field_q;
  logic [TW-1:0]     c_wake_s;
  logic [TW-1:0]     d_wake_s;
  logic [TW-1:0]     val;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      in_dat_q <= 1'b0;
      lane_q   <= '0;
      field_q  <= '0;
    end else if (step) begin
      if (!in_dat_q) begin
        if (field_q == CLK_LAST) begin
          in_dat_q <= 1'b1;
          field_q  <= '0;
        end else begin
          field_q <= field_q + 3'd1;
        end
      end else if (field_q == DAT_LAST) begin
        field_q <= '0;
        lane_q  <= lane_q + LANE_W'(1);
      end else begin
        field_q <= field_q + 3'd1;
      end
    end
  end

  // wakeup saturation to the all-ones value of the timing field
  assign c_wake_s = (|c_wake[WW-1:TW]) ? '1 : c_wake[TW-1:0];
  assign d_wake_s = (|d_wake[WW-1:TW]) ? '1 : d_wake[TW-1:0];

  always_comb begin
    val = '0;
    if (!in_dat_q) begin
      case (field_q)
        3'd0:    val = c_lpx;
        3'd1:    val = c_prep;
        3'd2:    val = c_zero;
        3'd3:    val = c_trail;
        default: val = c_wake_s;
      endcase
    end else begin
      case (field_q)
        3'd0:    val = d_lpx;
        3'd1:    val = d_prep;
        3'd2:    val = d_zero;
        3'd3:    val = d_trail;
        3'd4:    val = d_tago;
        3'd5:    val = d_taget;
        default: val = d_wake_s;
      endcase
    end
  end

  assign data_o = BUS_W'(val);
  assign addr_o = in_dat_q
                ? BUS_W'(DATA_BASE) + (BUS_W'(lane_q) << STRIDE_SH) + BUS_W'(field_q)
                : BUS_W'(CLK_BASE) + BUS_W'(field_q);
  assign last_o = in_dat_q && (field_q == DAT_LAST) && (lane_q == lanes - LANE_W'(1));

endmodule

// File: rtl/dphy_tseq.sv
module dphy_tseq
  import dphy_tseq_pkg::*;
#(
  parameter int LANE_MAX   = 4,
  parameter int TW         = 8,
  parameter int WW         = 16,
  parameter int BUS_W      = 32,
  parameter int CFG_W      = 16,
  parameter int STROBE_CYC = 2,
  parameter int STOP_WAIT  = 8'h30,
  parameter int CLK_BASE   = 32'h10010,
  parameter int DATA_BASE  = 32'h10020,
  parameter int STRIDE_SH  = 4,
  localparam int LANE_W    = $clog2(LANE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [LANE_W-1:0] lanes_i,
  input  logic [TW-1:0]     clk_lpx_i,
  input  logic [TW-1:0]     clk_prep_i,
  input  logic [TW-1:0]     clk_zero_i,
  input  logic [TW-1:0]     clk_trail_i,
  input  logic [WW-1:0]     clk_wake_i,
  input  logic [TW-1:0]     dat_lpx_i,
  input  logic [TW-1:0]     dat_prep_i,
  input  logic [TW-1:0]     dat_zero_i,
  input  logic [TW-1:0]     dat_trail_i,
  input  logic [TW-1:0]     dat_tago_i,
  input  logic [TW-1:0]     dat_taget_i,
  input  logic [WW-1:0]     dat_wake_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CFG_W-1:0]  if_cfg_o,
  output logic              if_cfg_we_o,
  output logic              phy_rstz_o,
  output logic [7:0]        tst_ctrl0_o,
  output logic [BUS_W-1:0]  tst_ctrl1_o,
  output logic              log_valid_o,
  output logic [BUS_W-1:0]  log_addr_o,
  output logic [BUS_W-1:0]  log_data_o
);

  top_st_e           ts_q;
  logic [LANE_W-1:0] lanes_q;
  logic [TW-1:0]     c_lpx_q, c_prep_q, c_zero_q, c_trail_q;
  logic [WW-1:0]     c_wake_q, d_wake_q;
  logic [TW-1:0]     d_lpx_q, d_prep_q, d_zero_q, d_trail_q, d_tago_q, d_taget_q;

  logic              accept;
  logic              go_clr, go_wr, ack, step, last;
  logic [BUS_W-1:0]  w_addr, w_data;

  assign accept = (ts_q == T_IDLE) && start_i;
  assign go_clr = (ts_q == T_CLR_GO);
  assign go_wr  = (ts_q == T_WR_GO);
  assign step   = (ts_q == T_WR_WAIT) && ack && !last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q        <= T_IDLE;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      if_cfg_o    <= '0;
      if_cfg_we_o <= 1'b0;
      phy_rstz_o  <= 1'b1;
      lanes_q     <= '0;
      c_lpx_q <= '0; c_prep_q <= '0; c_zero_q <= '0; c_trail_q <= '0; c_wake_q <= '0;
      d_lpx_q <= '0; d_prep_q <= '0; d_zero_q <= '0; d_trail_q <= '0;
      d_tago_q <= '0; d_taget_q <= '0; d_wake_q <= '0;
    end else begin
      done_o      <= 1'b0;
      if_cfg_we_o <= 1'b0;
      case (ts_q)
        T_IDLE: begin
          if (start_i) begin
            lanes_q   <= lanes_i;
            c_lpx_q   <= clk_lpx_i;   c_prep_q  <= clk_prep_i;
            c_zero_q  <= clk_zero_i;  c_trail_q <= clk_trail_i;
            c_wake_q  <= clk_wake_i;
            d_lpx_q   <= dat_lpx_i;   d_prep_q  <= dat_prep_i;
            d_zero_q  <= dat_zero_i;  d_trail_q <= dat_trail_i;
            d_tago_q  <= dat_tago_i;  d_taget_q <= dat_taget_i;
            d_wake_q  <= dat_wake_i;
            if_cfg_o    <= (CFG_W'(STOP_WAIT) << 8) | CFG_W'(lanes_i - LANE_W'(1));
            if_cfg_we_o <= 1'b1;
            phy_rstz_o  <= 1'b0;
            busy_o      <= 1'b1;
            ts_q        <= T_CLR_GO;
          end
        end
        T_CLR_GO:   ts_q <= T_CLR_WAIT;
        T_CLR_WAIT: if (ack) ts_q <= T_WR_GO;
        T_WR_GO:    ts_q <= T_WR_WAIT;
        T_WR_WAIT: begin
          if (ack) begin
            if (last) begin
              done_o <= 1'b1;
              busy_o <= 1'b0;
              ts_q   <= T_IDLE;
            end else begin
              ts_q <= T_WR_GO;
            end
          end
        end
        default: ts_q <= T_IDLE;
      endcase
    end
  end

  dphy_tseq_walk #(
    .LANE_W(LANE_W), .TW(TW), .WW(WW), .BUS_W(BUS_W),
    .CLK_BASE(CLK_BASE), .DATA_BASE(DATA_BASE), .STRIDE_SH(STRIDE_SH)
  ) u_walk (
    .clk(clk), .rst(rst), .init(accept), .step(step), .lanes(lanes_q),
    .c_lpx(c_lpx_q), .c_prep(c_prep_q), .c_zero(c_zero_q), .c_trail(c_trail_q),
    .c_wake(c_wake_q),
    .d_lpx(d_lpx_q), .d_prep(d_prep_q), .d_zero(d_zero_q), .d_trail(d_trail_q),
    .d_tago(d_tago_q), .d_taget(d_taget_q), .d_wake(d_wake_q),
    .addr_o(w_addr), .data_o(w_data), .last_o(last)
  );

  dphy_tseq_xfer #(
    .BUS_W(BUS_W), .STROBE_CYC(STROBE_CYC)
  ) u_xfer (
    .clk(clk), .rst(rst), .go_clr(go_clr), .go_wr(go_wr),
    .addr_i(w_addr), .data_i(w_data), .ack_o(ack),
    .ctrl0_o(tst_ctrl0_o), .ctrl1_o(tst_ctrl1_o),
    .log_valid_o(log_valid_o), .log_addr_o(log_addr_o), .log_data_o(log_data_o)
  );

endmodule

// File: rtl/dphy_tseq_chk.sv
module dphy_tseq_chk #(
  parameter int BUS_W      = 32,
  parameter int CFG_W      = 16,
  parameter int STROBE_CYC = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             busy_o,
  input logic             done_o,
  input logic             if_cfg_we_o,
  input logic             phy_rstz_o,
  input logic [7:0]       tst_ctrl0_o,
  input logic [BUS_W-1:0] tst_ctrl1_o,
  input logic             log_valid_o
);

  logic [15:0] stb_run;

  always_ff @(posedge clk) begin
    if (rst)                      stb_run <= '0;
    else if (tst_ctrl0_o == 8'h02) stb_run <= stb_run + 16'd1;
    else                          stb_run <= '0;
  end

  // R5: bus held while the strobe is high
  a_r5_bus_stable: assert property (@(posedge clk) disable iff (rst)
    (tst_ctrl0_o == 8'h02) |-> $stable(tst_ctrl1_o));

  // R5: strobe always rises out of the idle control value
  a_r5_strobe_from_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(tst_ctrl0_o == 8'h02) |-> ($past(tst_ctrl0_o) == 8'h00));

  // R5: strobe width equals STROBE_CYC
  a_r5_strobe_width: assert property (@(posedge clk) disable iff (rst)
    ((tst_ctrl0_o != 8'h02) && (stb_run != 16'd0)) |-> (stb_run == 16'(STROBE_CYC)));

  // R3: reset-n low during a run
  a_r3_rstz_low: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !phy_rstz_o);

  // R9: log valid is a single-cycle pulse
  a_r9_log_pulse: assert property (@(posedge clk) disable iff (rst)
    log_valid_o |=> !log_valid_o);

  // R10: done is a single-cycle pulse after the last log entry
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r10_done_after_log: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(log_valid_o));

  // R11: configuration written only when a run is accepted from idle
  a_r11_cfg_from_idle: assert property (@(posedge clk) disable iff (rst)
    if_cfg_we_o |-> !$past(busy_o));

endmodule

bind dphy_tseq dphy_tseq_chk #(
  .BUS_W(BUS_W), .CFG_W(CFG_W), .STROBE_CYC(STROBE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o),
  .if_cfg_we_o(if_cfg_we_o), .phy_rstz_o(phy_rstz_o),
  .tst_ctrl0_o(tst_ctrl0_o), .tst_ctrl1_o(tst_ctrl1_o),
  .log_valid_o(log_valid_o)
);

// File: tb/dphy_tseq_tb_top.sv
`timescale 1ns/1ps
module dphy_tseq_tb_top;

  localparam int STB = 2;
  localparam int NV  = 4;
  // {lanes[7:0], clk_wake[15:0], dat_wake[15:0], base[7:0]}
  localparam logic [47:0] VEC [NV] = '{
    {8'd1, 16'h0040, 16'h00FF, 8'h10},
    {8'd2, 16'h0100, 16'h0055, 8'h21},
    {8'd3, 16'h00FE, 16'hFFFF, 8'h30},
    {8'd4, 16'h1234, 16'h0001, 8'hA0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        start_i = 1'b0;
  logic [2:0]  lanes_i = 3'd1;
  logic [7:0]  c_lpx = 0, c_prep = 0, c_zero = 0, c_trail = 0;
  logic [15:0] c_wake = 0, d_wake = 0;
  logic [7:0]  d_lpx = 0, d_prep = 0, d_zero = 0, d_trail = 0, d_tago = 0, d_taget = 0;

  logic        busy_o, done_o, if_cfg_we_o, phy_rstz_o, log_valid_o;
  logic [15:0] if_cfg_o;
  logic [7:0]  tst_ctrl0_o;
  logic [31:0] tst_ctrl1_o, log_addr_o, log_data_o;

  dphy_tseq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .lanes_i(lanes_i),
    .clk_lpx_i(c_lpx), .clk_prep_i(c_prep), .clk_zero_i(c_zero),
    .clk_trail_i(c_trail), .clk_wake_i(c_wake),
    .dat_lpx_i(d_lpx), .dat_prep_i(d_prep), .dat_zero_i(d_zero),
    .dat_trail_i(d_trail), .dat_tago_i(d_tago), .dat_taget_i(d_taget),
    .dat_wake_i(d_wake),
    .busy_o(busy_o), .done_o(done_o), .if_cfg_o(if_cfg_o),
    .if_cfg_we_o(if_cfg_we_o), .phy_rstz_o(phy_rstz_o),
    .tst_ctrl0_o(tst_ctrl0_o), .tst_ctrl1_o(tst_ctrl1_o),
    .log_valid_o(log_valid_o), .log_addr_o(log_addr_o), .log_data_o(log_data_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- pin monitor ----------------
  logic        mon_clr = 1'b0;
  logic [31:0] pin_w [80];
  logic [31:0] lg_a [40];
  logic [31:0] lg_d [40];
  int pin_n, lg_n, clr_n, clr_at, cfg_n, done_n, bad_w, bad_stab, bad_rstz, bad_done;
  logic [15:0] cfg_val;
  logic [7:0]  p0;
  logic [31:0] p1;
  int          run;

  always @(negedge clk) begin
    if (mon_clr || rst) begin
      pin_n = 0; lg_n = 0; clr_n = 0; clr_at = -1; cfg_n = 0; done_n = 0;
      bad_w = 0; bad_stab = 0; bad_rstz = 0; bad_done = 0; run = 0; cfg_val = 0;
      p0 = tst_ctrl0_o; p1 = tst_ctrl1_o;
    end else begin
      if (tst_ctrl0_o == 8'h02 && p0 != 8'h02) begin
        if (pin_n < 80) pin_w[pin_n] = tst_ctrl1_o;
        pin_n++;
        run = 1;
      end else if (tst_ctrl0_o == 8'h02) begin
        run++;
        if (tst_ctrl1_o != p1) bad_stab++;
      end else if (tst_ctrl0_o == 8'h01 && p0 != 8'h01) begin
        clr_n++; clr_at = pin_n; run = 1;
      end else if (tst_ctrl0_o == 8'h01) begin
        run++;
      end
      if ((p0 == 8'h02 || p0 == 8'h01) && tst_ctrl0_o != p0) begin
        if (tst_ctrl0_o != 8'h00 || run != STB) bad_w++;
      end
      if (log_valid_o) begin
        if (lg_n < 40) begin lg_a[lg_n] = log_addr_o; lg_d[lg_n] = log_data_o; end
        lg_n++;
      end
      if (if_cfg_we_o) begin cfg_n++; cfg_val = if_cfg_o; end
      if (busy_o && phy_rstz_o) bad_rstz++;
      if (done_o) done_n++;
      if (done_o && lg_n == 0) bad_done++;
      p0 = tst_ctrl0_o; p1 = tst_ctrl1_o;
    end
  end

  // ---------------- expected model ----------------
  function automatic logic [7:0] sat(input logic [15:0] w);
    return (w > 16'h00FF) ? 8'hFF : w[7:0];
  endfunction

  function automatic logic [31:0] exp_addr(input int k);
    if (k < 5) return 32'h10010 + k;
    return 32'h10020 + ((k - 5) / 7) * 16 + ((k - 5) % 7);
  endfunction

  function automatic logic [31:0] exp_data(input int k, input logic [7:0] b,
                                           input logic [15:0] cw, input logic [15:0] dw);
    int f;
    if (k < 5) return (k == 4) ? {24'h0, sat(cw)} : {24'h0, b + 8'(k)};
    f = (k - 5) % 7;
    return (f == 6) ? {24'h0, sat(dw)} : {24'h0, b + 8'(4 + f)};
  endfunction

  task automatic load(input logic [47:0] v);
    lanes_i = v[42:40];
    c_wake  = v[39:24];
    d_wake  = v[23:8];
    c_lpx = v[7:0];        c_prep = v[7:0] + 8'd1;
    c_zero = v[7:0] + 8'd2; c_trail = v[7:0] + 8'd3;
    d_lpx = v[7:0] + 8'd4;  d_prep = v[7:0] + 8'd5;
    d_zero = v[7:0] + 8'd6; d_trail = v[7:0] + 8'd7;
    d_tago = v[7:0] + 8'd8; d_taget = v[7:0] + 8'd9;
  endtask

  task automatic clear_mon();
    mon_clr = 1'b1;
    @(negedge clk); @(negedge clk);
    mon_clr = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (done_o) begin ok = 1'b1; break; end
    end
  endtask

  task automatic verify_run(input logic [47:0] v, input int lanes);
    int n;
    n = 5 + 7 * lanes;
    check(cfg_n == 1, "R2 cfg pulses", cfg_n, 1);
    check(cfg_val == {8'h30, 8'(lanes - 1)}, "R2 cfg word", cfg_val, {8'h30, 8'(lanes - 1)});
    check(bad_rstz == 0 && phy_rstz_o == 1'b0, "R3 reset-n low", bad_rstz, 0);
    check(clr_n == 1 && clr_at == 0, "R4 clear sequence", clr_n, 1);
    check(bad_w == 0 && bad_stab == 0, "R5 strobe shape", bad_w + bad_stab, 0);
    check(pin_n == 2 * n, "R7 bus phase count", pin_n, 2 * n);
    for (int k = 0; k < n && k < 40; k++) begin
      check(pin_w[2*k] == exp_addr(k), (k < 5) ? "R6 clock address" : "R7 lane address",
            pin_w[2*k], exp_addr(k));
      check(pin_w[2*k+1] == exp_data(k, v[7:0], v[39:24], v[23:8]), "R8 bus data",
            pin_w[2*k+1], exp_data(k, v[7:0], v[39:24], v[23:8]));
    end
    check(lg_n == n, "R9 log count", lg_n, n);
    for (int k = 0; k < n && k < 40; k++) begin
      check(lg_a[k] == exp_addr(k) && lg_d[k] == exp_data(k, v[7:0], v[39:24], v[23:8]),
            "R9 log entry", lg_a[k], exp_addr(k));
    end
    check(done_n == 1 && bad_done == 0, "R10 done pulse", done_n, 1);
    check(busy_o == 1'b0, "R10 busy cleared", busy_o, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #700000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy_o == 0 && done_o == 0 && log_valid_o == 0 && if_cfg_we_o == 0,
          "R1 idle outputs", {busy_o, done_o, log_valid_o, if_cfg_we_o}, 0);
    check(tst_ctrl0_o == 8'h00 && phy_rstz_o == 1'b1, "R1 ctrl/rstz", {tst_ctrl0_o, phy_rstz_o}, 1);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i]);
      clear_mon();
      pulse_start();
      wait_done(ok);
      check(ok, "R10 done seen", ok, 1);
      @(negedge clk);
      verify_run(VEC[i], int'(VEC[i][42:40]));
      repeat (5) @(negedge clk);
    end

    // R11: start while busy is ignored
    load(VEC[1]);
    clear_mon();
    pulse_start();
    repeat (20) @(negedge clk);
    load(VEC[3]);
    pulse_start();
    load(VEC[1]);
    wait_done(ok);
    @(negedge clk);
    verify_run(VEC[1], 2);
    repeat (300) @(negedge clk);
    check(lg_n == 19 && busy_o == 1'b0, "R11 no second run", lg_n, 19);
    check(cfg_n == 1, "R11 cfg written once", cfg_n, 1);

    // R1: reset in the middle of a run
    load(VEC[2]);
    clear_mon();
    pulse_start();
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(busy_o == 0 && tst_ctrl0_o == 8'h00 && phy_rstz_o == 1'b1 && log_valid_o == 0,
          "R1 reset mid-run", {busy_o, tst_ctrl0_o, phy_rstz_o}, 1);
    rst = 1'b0;
    @(negedge clk);
    load(VEC[0]);
    clear_mon();
    pulse_start();
    wait_done(ok);
    check(ok, "R10 done after reset", ok, 1);
    @(negedge clk);
    verify_run(VEC[0], 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule